// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block gives a host on a byte-wide, ISA-style I/O bus guarded access to a bank of 256 eight-bit configuration registers. Two bus addresses are decoded: an index port and a data port. Out of reset the port is closed, and the bus can do nothing but present the opening key. Once open, a byte written to the index port picks a register, and the data port then reads or writes that register. A closing key written to the index port shuts access again.

The lock is a two-state machine. `ST_LOCKED` is the reset state. The transition `OPEN_KEY` (a write of 0xAA to the index port) goes to `ST_OPEN`. The transition `CLOSE_KEY` (a write of 0x55 to the index port while open) returns to `ST_LOCKED`. Every other access leaves the state unchanged. The key compare is made before the index load, so the closing key can never become an index. One bit of one register, bit 7 of register 0xC1, is driven straight out as an enable for a separate plug-and-play register interface.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is in `ST_LOCKED` and `pnp_en` is 0.
- R2: In `ST_LOCKED`, a write of 0xAA to the index port (0x108) moves the port to `ST_OPEN`.
- R3: In `ST_LOCKED`, writes to the data port and writes of any byte other than 0xAA to the index port change neither the index, nor any register, nor `pnp_en`.
- R4: In `ST_LOCKED`, reads of the index port and of the data port return 0xFF.
- R5: In `ST_OPEN`, a write of 0x55 to the index port returns the port to `ST_LOCKED` and leaves the index unchanged.
- R6: In `ST_OPEN`, a write of any other byte to the index port, 0xAA included, becomes the current index, and a read of the index port returns it.
- R7: In `ST_OPEN`, a write to the data port (0x109) stores the byte in the register chosen by the index, and a read of the data port returns that register.
- R8: `pnp_en` equals bit 7 of register 0xC1 and changes in the clock cycle after the write that sets or clears that bit.
- R9: Accesses at any other address are ignored, and reads there return 0xFF.
- R10: All 256 registers and the index reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| pnp_en | output | 1 | Bit 7 of register 0xC1 |

## Verification
A lock state that went wrong would show up on the very next read. A port that opened too early would return the index or register data in place of 0xFF. A port that stayed closed would keep returning 0xFF after the key. An index that took the closing key, or that moved while the port was locked, would show up at the next index-port read. Register storage errors would show up on the next data-port read of that register, and a wrong bit 0xC1[7] would show on `pnp_en` one cycle after the write. The bench therefore reads back after every step and checks `pnp_en` after every write.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_READ = 8'hFF;
endpackage

// File: rtl/keyed_cfg_lock_fsm.sv
module keyed_cfg_lock_fsm
    import keyed_cfg_pkg::*;
#(
    parameter int unsigned IDX_W      = 8,
    parameter logic [7:0]  OPEN_KEY   = 8'hAA,
    parameter logic [7:0]  CLOSE_KEY  = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [7:0]       wdata,
    output logic             is_open,
    output logic [IDX_W-1:0] index
);
    lock_state_e state_q, state_d;
    logic        load_idx;

    always_comb begin
        state_d  = state_q;
        load_idx = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == OPEN_KEY)
                    state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (idx_wr) begin
                    if (wdata == CLOSE_KEY)
                        state_d = ST_LOCKED;
                    else
                        load_idx = 1'b1;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LOCKED;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            index <= '0;
        else if (load_idx)
            index <= wdata[IDX_W-1:0];
    end

    assign is_open = (state_q == ST_OPEN);
endmodule

// File: rtl/keyed_cfg_regfile.sv
module keyed_cfg_regfile #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned PNP_REG = 8'hC1,
    parameter int unsigned PNP_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             pnp_bit
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[sel] <= wdata;
        end
    end

    assign rdata   = mem[sel];
    assign pnp_bit = mem[PNP_REG][PNP_BIT];
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import keyed_cfg_pkg::*;
#(
    parameter int unsigned  AW         = 16,
    parameter logic [AW-1:0] INDEX_PORT = 16'h0108,
    parameter logic [AW-1:0] DATA_PORT  = 16'h0109,
    parameter logic [7:0]   OPEN_KEY   = 8'hAA,
    parameter logic [7:0]   CLOSE_KEY  = 8'h55,
    parameter int unsigned  PNP_REG    = 8'hC1,
    parameter int unsigned  PNP_BIT    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [7:0]    bus_rdata,
    output logic          pnp_en
);
    localparam int unsigned IDX_W = 8;

    logic             hit_idx, hit_data;
    logic             is_open;
    logic [IDX_W-1:0] index;
    logic [7:0]       reg_rd;

    assign hit_idx  = (bus_addr == INDEX_PORT);
    assign hit_data = (bus_addr == DATA_PORT);

    keyed_cfg_lock_fsm #(
        .IDX_W     (IDX_W),
        .OPEN_KEY  (OPEN_KEY),
        .CLOSE_KEY (CLOSE_KEY)
    ) lock_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (bus_wr && hit_idx),
        .wdata   (bus_wdata),
        .is_open (is_open),
        .index   (index)
    );

    keyed_cfg_regfile #(
        .IDX_W   (IDX_W),
        .PNP_REG (PNP_REG),
        .PNP_BIT (PNP_BIT)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_wr && hit_data && is_open),
        .sel     (index),
        .wdata   (bus_wdata),
        .rdata   (reg_rd),
        .pnp_bit (pnp_en)
    );

    always_comb begin
        bus_rdata = IDLE_READ;
        if (bus_rd && is_open) begin
            if (hit_idx)
                bus_rdata = index;
            else if (hit_data)
                bus_rdata = reg_rd;
        end
    end
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
    parameter int unsigned   AW         = 16,
    parameter logic [AW-1:0] INDEX_PORT = 16'h0108,
    parameter logic [AW-1:0] DATA_PORT  = 16'h0109,
    parameter logic [7:0]    OPEN_KEY   = 8'hAA,
    parameter logic [7:0]    CLOSE_KEY  = 8'h55,
    parameter int unsigned   PNP_REG    = 8'hC1,
    parameter int unsigned   PNP_BIT    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_rdata,
    input logic          pnp_en,
    input logic          is_open,
    input logic [7:0]    index
);
    logic key_open_wr, key_close_wr, idx_wr, pnp_wr;
    assign idx_wr       = bus_wr && bus_addr == INDEX_PORT;
    assign key_open_wr  = idx_wr && bus_wdata == OPEN_KEY;
    assign key_close_wr = idx_wr && bus_wdata == CLOSE_KEY;
    assign pnp_wr       = is_open && bus_wr && bus_addr == DATA_PORT && index == PNP_REG[7:0];

    // R2
    open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_open && key_open_wr |=> is_open);

    // R3
    stay_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_open && !key_open_wr |=> !is_open && $stable(index) && $stable(pnp_en));

    // R4
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_open && bus_rd |-> bus_rdata == 8'hFF);

    // R5
    close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_open && key_close_wr |=> !is_open && $stable(index));

    // R6
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_open && idx_wr && !key_close_wr |=> is_open && index == $past(bus_wdata));

    // R8
    pnp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pnp_wr |=> pnp_en == $past(bus_wdata[PNP_BIT]));

    // R8
    pnp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pnp_wr |=> $stable(pnp_en));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
    .AW(AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
    .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY),
    .PNP_REG(PNP_REG), .PNP_BIT(PNP_BIT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pnp_en(pnp_en),
    .is_open(is_open), .index(index)
);

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;
    localparam logic [15:0] IDX_A  = 16'h0108;
    localparam logic [15:0] DATA_A = 16'h0109;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        pnp_en;

    int checks = 0;
    int fails  = 0;

    bit         m_open;
    logic [7:0] m_idx;
    logic [7:0] m_regs [256];

    always #10 clk = ~clk;

    keyed_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pnp_en(pnp_en)
    );

    function automatic logic [7:0] exp_read(logic [15:0] a);
        if (!m_open) return 8'hFF;
        if (a == IDX_A) return m_idx;
        if (a == DATA_A) return m_regs[m_idx];
        return 8'hFF;
    endfunction

    function automatic string read_tag(logic [15:0] a);
        if (!m_open) return "R4";
        if (a == IDX_A) return "R6";
        if (a == DATA_A) return "R7";
        return "R9";
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        if (!m_open) begin
            if (a == IDX_A && d == 8'hAA) m_open = 1'b1;
        end else if (a == IDX_A) begin
            if (d == 8'h55) m_open = 1'b0;
            else m_idx = d;
        end else if (a == DATA_A) begin
            m_regs[m_idx] = d;
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        #2;
        check("R8", {7'd0, pnp_en}, {7'd0, m_regs[8'hC1][7]});
    endtask

    task automatic bus_read(logic [15:0] a, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        check(tag, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        int unsigned sel;
        sel = $urandom(32'd20240611);
        m_open = 1'b0;
        m_idx  = '0;
        for (int i = 0; i < 256; i++) m_regs[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1", {7'd0, pnp_en}, 8'd0);
        bus_read(IDX_A, "R4");
        bus_read(DATA_A, "R4");

        // R3: locked writes have no effect
        bus_write(IDX_A, 8'hC1);
        bus_write(DATA_A, 8'h80);
        bus_write(IDX_A, 8'h55);
        bus_read(DATA_A, "R4");
        // R2: open key
        bus_write(IDX_A, 8'hAA);
        bus_read(IDX_A, "R3");
        bus_read(DATA_A, "R3");

        // R10: every register resets to zero (0x55 cannot be an index)
        for (int r = 0; r < 256; r++) begin
            if (r != 8'h55) begin
                bus_write(IDX_A, 8'(r));
                bus_read(DATA_A, "R10");
            end
        end

        // R7: store and read back
        bus_write(IDX_A, 8'h12);
        bus_write(DATA_A, 8'h3C);
        bus_read(DATA_A, "R7");

        // R5: close key does not load the index
        bus_write(IDX_A, 8'h55);
        bus_read(IDX_A, "R5");
        bus_write(IDX_A, 8'hAA);
        bus_read(IDX_A, "R5");

        // R6: open key while open becomes an index
        bus_write(IDX_A, 8'hAA);
        bus_read(IDX_A, "R6");

        // R8: enable output follows 0xC1 bit 7
        bus_write(IDX_A, 8'hC1);
        bus_write(DATA_A, 8'h80);
        check("R8", {7'd0, pnp_en}, 8'd1);
        bus_write(DATA_A, 8'h7F);
        check("R8", {7'd0, pnp_en}, 8'd0);
        bus_write(DATA_A, 8'hFF);

        // R9: other addresses ignored
        bus_write(16'h010A, 8'h00);
        bus_read(16'h010A, "R9");
        bus_read(DATA_A, "R9");

        // R3: locked data write leaves 0xC1 and pnp_en alone
        bus_write(IDX_A, 8'h55);
        bus_write(DATA_A, 8'h00);
        bus_write(IDX_A, 8'hAA);
        bus_read(DATA_A, "R3");

        // random mix
        for (int n = 0; n < 2000; n++) begin
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1, 2: a = IDX_A;
                3, 4, 5, 6: a = DATA_A;
                7: a = 16'h0208;
                default: a = 16'h0109 ^ 16'(1 << $urandom_range(2, 15));
            endcase
            sel = $urandom_range(0, 9);
            case (sel)
                0: d = 8'hAA;
                1: d = 8'h55;
                2: d = 8'hC1;
                3: d = 8'(8'hC0 + $urandom_range(0, 3));
                default: d = 8'($urandom);
            endcase
            if ($urandom_range(0, 1) == 0) bus_write(a, d);
            else bus_read(a, read_tag(a));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule